// File: doc/BRIEF.md
# Complementary Output Dead-Time Inserter

This block sits between a PWM counter/comparator and the output pads of a timer. For each of its channels it takes one logical PWM level and drives a main pin and, in paired mode, a complementary pin that is logically active while the main side is inactive. A single dead-time count, shared by every channel, delays each output's inactive-to-active edge. This leaves a gap at every change of the PWM level in which neither side is logically active. Active-to-inactive edges are not delayed.

Dead time acts on logical levels. The per-pin polarity inversion comes after it. During the gap each pin therefore shows its own inactive level, so the two pins can both be high or both be low. Each pin has an output-enable. A disabled channel, or a channel in reset, drives neither pin. A shared force-safe input takes every channel's outputs to the logical inactive state without disabling the drivers. All pins are plain level signals sampled on the rising clock edge. There is no data stream and no handshake, so back-pressure does not arise.

The dead-time input is clamped to the parameter MAX_DT, which defaults to 4032 cycles. Timing rule: for each channel the block counts the consecutive rising edges at which `pwm_in` has held its current value, including the present edge. This count is called the run length.

Top module: `dti_inserter`

## Requirements
- R1: While `rst_n` is low, every `main_oe` and `comp_oe` bit is 0 and all logical outputs are inactive.
- R2: One edge after a channel's `ch_enable` bit is sampled 0, both of that channel's output-enables are 0.
- R3: With `pair_mode`=0 on an enabled channel, `comp_oe` is 0 and the main output's logical level equals `pwm_in` sampled at the previous edge, with no dead time.
- R4: In paired mode the main output becomes logically active after the first edge at which `pwm_in` is 1 with a run length greater than the effective dead time.
- R5: In paired mode the complementary output becomes logically active after the first edge at which `pwm_in` is 0 with a run length greater than the effective dead time.
- R6: After an edge that samples `pwm_in`=0, the main output is logically inactive. After an edge that samples `pwm_in`=1, the complementary output is logically inactive. Neither of these waits for the dead time.
- R7: The main and complementary outputs of a channel are never logically active in the same cycle.
- R8: A PWM level held for no more edges than the dead time never activates the delayed output, so no runt pulse is produced.
- R9: With an effective dead time of 0 in paired mode, the complementary output is the exact logical inverse of the main output in every cycle.
- R10: Pin level = logical level XOR the polarity bit (`main_act_low`/`comp_act_low`, where 1 means active-low). A polarity change takes effect in the same cycle, and during the dead-time gap both pins show their inactive levels.
- R11: A `dead_time` value above MAX_DT behaves exactly as MAX_DT.
- R12: One edge after `force_safe` is sampled 1, every output is logically inactive, and the output-enables keep following `ch_enable`/`pair_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dead_time | input | DT_W | Shared dead-time count in clock cycles |
| force_safe | input | 1 | Forces all outputs logically inactive |
| pwm_in | input | NCH | Logical PWM level per channel |
| ch_enable | input | NCH | Channel output enable |
| pair_mode | input | NCH | 1: complementary pair, 0: main output only |
| main_act_low | input | NCH | Main pin polarity, 1 = active-low |
| comp_act_low | input | NCH | Complementary pin polarity, 1 = active-low |
| main_pin | output | NCH | Main pin level |
| main_oe | output | NCH | Main pin driver enable (0 = high-impedance) |
| comp_pin | output | NCH | Complementary pin level |
| comp_oe | output | NCH | Complementary pin driver enable |

## Verification
The bench builds the block with NCH=3, DT_W=12 and MAX_DT=40. A small clamp limit means dead-time codes far above the limit saturate the run-length counter within a few dozen cycles, which brings R11 and the saturation path within reach. Three channels run independent random PWM patterns, with random polarity, mode and enable settings, against one shared dead time. Dead times of 0 and 1 and values next to the clamp are driven on purpose, together with pulses shorter than, equal to and one longer than the gap.

// File: rtl/dti_pkg.sv
package dti_pkg;

  localparam int unsigned DTI_DEF_MAX_DT = 4032;

  // Width of a run-length counter that must reach max_dt + 1.
  function automatic int unsigned dti_cnt_w(input int unsigned max_dt);
    return $clog2(max_dt + 2);
  endfunction

  typedef struct packed {
    logic main_on;
    logic comp_on;
  } dti_act_t;

  typedef struct packed {
    logic main_oe;
    logic comp_oe;
  } dti_oe_t;

endpackage

// File: rtl/dti_dt_clamp.sv
module dti_dt_clamp #(
  parameter int unsigned DT_W   = 12,
  parameter int unsigned MAX_DT = 4032,
  parameter int unsigned CW     = 13
) (
  input  logic [DT_W-1:0] dt_raw,
  output logic [CW-1:0]   dt_eff
);
  localparam int unsigned WW = (DT_W > CW) ? DT_W : CW;

  logic [WW-1:0] raw_w;
  logic [WW-1:0] lim_w;

  always_comb begin
    raw_w  = WW'(dt_raw);
    lim_w  = WW'(MAX_DT);
    dt_eff = (raw_w > lim_w) ? CW'(MAX_DT) : CW'(raw_w);
  end
endmodule

// File: rtl/dti_chan_core.sv
module dti_chan_core
  import dti_pkg::*;
#(
  parameter int unsigned MAX_DT = 4032,
  parameter int unsigned CW     = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm,
  input  logic          en,
  input  logic          pair,
  input  logic          force_safe,
  input  logic [CW-1:0] dt_eff,
  output dti_act_t      act_q,
  output dti_oe_t       oe_q
);
  localparam logic [CW-1:0] RUN_SAT = CW'(MAX_DT + 1);

  logic          pwm_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;
  logic          settled;
  logic          gated;
  dti_act_t      act_nx;
  dti_oe_t       oe_nx;

  // Run length: edges at which pwm has held its current level, this one included.
  always_comb begin
    if (pwm != pwm_q)          run_nx = CW'(1);
    else if (run_q >= RUN_SAT) run_nx = RUN_SAT;
    else                       run_nx = run_q + CW'(1);
  end

  always_comb begin
    settled = (run_nx > dt_eff);
    gated   = en && !force_safe;
    act_nx.main_on = gated && pwm && (!pair || settled);
    act_nx.comp_on = gated && pair && !pwm && settled;
    oe_nx.main_oe  = en;
    oe_nx.comp_oe  = en && pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      run_q <= '0;
      act_q <= '0;
      oe_q  <= '0;
    end else begin
      pwm_q <= pwm;
      run_q <= run_nx;
      act_q <= act_nx;
      oe_q  <= oe_nx;
    end
  end
endmodule

// File: rtl/dti_pin_map.sv
module dti_pin_map
  import dti_pkg::*;
(
  input  dti_act_t act,
  input  dti_oe_t  oe,
  input  logic     main_low,
  input  logic     comp_low,
  output logic     main_pin,
  output logic     main_oe,
  output logic     comp_pin,
  output logic     comp_oe
);
  always_comb begin
    main_pin = act.main_on ^ main_low;
    comp_pin = act.comp_on ^ comp_low;
    main_oe  = oe.main_oe;
    comp_oe  = oe.comp_oe;
  end
endmodule

// File: rtl/dti_inserter.sv
module dti_inserter
  import dti_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DT_W   = 12,
  parameter int unsigned MAX_DT = DTI_DEF_MAX_DT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_time,
  input  logic            force_safe,
  input  logic [NCH-1:0]  pwm_in,
  input  logic [NCH-1:0]  ch_enable,
  input  logic [NCH-1:0]  pair_mode,
  input  logic [NCH-1:0]  main_act_low,
  input  logic [NCH-1:0]  comp_act_low,
  output logic [NCH-1:0]  main_pin,
  output logic [NCH-1:0]  main_oe,
  output logic [NCH-1:0]  comp_pin,
  output logic [NCH-1:0]  comp_oe
);
  localparam int unsigned CW = dti_cnt_w(MAX_DT);

  logic [CW-1:0] dt_eff;

  dti_dt_clamp #(.DT_W(DT_W), .MAX_DT(MAX_DT), .CW(CW)) u_clamp (
    .dt_raw (dead_time),
    .dt_eff (dt_eff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dti_act_t act;
    dti_oe_t  oe;

    dti_chan_core #(.MAX_DT(MAX_DT), .CW(CW)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwm        (pwm_in[c]),
      .en         (ch_enable[c]),
      .pair       (pair_mode[c]),
      .force_safe (force_safe),
      .dt_eff     (dt_eff),
      .act_q      (act),
      .oe_q       (oe)
    );

    dti_pin_map u_map (
      .act      (act),
      .oe       (oe),
      .main_low (main_act_low[c]),
      .comp_low (comp_act_low[c]),
      .main_pin (main_pin[c]),
      .main_oe  (main_oe[c]),
      .comp_pin (comp_pin[c]),
      .comp_oe  (comp_oe[c])
    );
  end
endmodule

// File: rtl/dti_inserter_chk.sv
module dti_inserter_chk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DT_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DT_W-1:0] dead_time,
  input logic            force_safe,
  input logic [NCH-1:0]  pwm_in,
  input logic [NCH-1:0]  ch_enable,
  input logic [NCH-1:0]  pair_mode,
  input logic [NCH-1:0]  main_act_low,
  input logic [NCH-1:0]  comp_act_low,
  input logic [NCH-1:0]  main_pin,
  input logic [NCH-1:0]  main_oe,
  input logic [NCH-1:0]  comp_pin,
  input logic [NCH-1:0]  comp_oe
);
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      p_reset_hiz_r1: assert ((main_oe | comp_oe) == '0)
        else $error("R1: driver enabled during reset");
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic m_l, c_l;
    assign m_l = main_pin[c] ^ main_act_low[c];
    assign c_l = comp_pin[c] ^ comp_act_low[c];

    p_disabled_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(!ch_enable[c]) |-> !main_oe[c] && !comp_oe[c]);

    p_single_no_comp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(!pair_mode[c]) |-> !comp_oe[c]);

    p_fast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(!pwm_in[c]) |-> !m_l);

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_l && c_l));

    p_zero_dt_inverse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(ch_enable[c] && pair_mode[c] && !force_safe && dead_time == '0)
      |-> m_l != c_l);

    p_force_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && $past(force_safe) |-> !m_l && !c_l);
  end
endmodule

bind dti_inserter dti_inserter_chk #(.NCH(NCH), .DT_W(DT_W)) u_chk (.*);

// File: tb/dti_inserter_bench.sv
module dti_inserter_bench;
  localparam int NCH = 3;
  localparam int DT_W = 12;
  localparam int MAXDT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DT_W-1:0] dead_time = '0;
  logic force_safe = 1'b0;
  logic [NCH-1:0] pwm_in = '0, ch_enable = '0, pair_mode = '0;
  logic [NCH-1:0] main_act_low = '0, comp_act_low = '0;
  logic [NCH-1:0] main_pin, main_oe, comp_pin, comp_oe;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit sb_on = 1'b0;

  always #10 clk = ~clk;

  dti_inserter #(.NCH(NCH), .DT_W(DT_W), .MAX_DT(MAXDT)) u_dti_inserter (.*);

  // Reference model built from the requirement text.
  bit m_prev[NCH];
  int m_run[NCH];
  bit m_main[NCH], m_comp[NCH], m_moe[NCH], m_coe[NCH];

  function automatic int eff_dt();
    return (int'(dead_time) > MAXDT) ? MAXDT : int'(dead_time);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_prev[c] = 0; m_run[c] = 0; m_main[c] = 0; m_comp[c] = 0;
        m_moe[c] = 0; m_coe[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int r;
        bit ok;
        r = (pwm_in[c] != m_prev[c]) ? 1 : ((m_run[c] >= MAXDT + 1) ? MAXDT + 1 : m_run[c] + 1);
        ok = r > eff_dt();
        m_main[c] = ch_enable[c] && !force_safe && pwm_in[c] && (!pair_mode[c] || ok);
        m_comp[c] = ch_enable[c] && !force_safe && pair_mode[c] && !pwm_in[c] && ok;
        m_moe[c] = ch_enable[c];
        m_coe[c] = ch_enable[c] && pair_mode[c];
        m_prev[c] = pwm_in[c];
        m_run[c] = r;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic string req_of(int c);
    if (force_safe) return "R12";
    if (!ch_enable[c]) return "R2";
    if (!pair_mode[c]) return "R3";
    if (eff_dt() == 0) return "R9";
    if (int'(dead_time) > MAXDT) return "R11";
    return "R4 R5";
  endfunction

  // Scoreboard, sampled 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (sb_on) begin
      for (int c = 0; c < NCH; c++) begin
        string q;
        q = req_of(c);
        chk(q, "main_oe", main_oe[c], m_moe[c]);
        chk(q, "comp_oe", comp_oe[c], m_coe[c]);
        if (main_oe[c]) chk(q, "main_pin", main_pin[c], m_main[c] ^ main_act_low[c]);
        if (comp_oe[c]) chk(q, "comp_pin", comp_pin[c], m_comp[c] ^ comp_act_low[c]);
        chk("R7", "both active", (main_pin[c] ^ main_act_low[c]) & (comp_pin[c] ^ comp_act_low[c]), 0);
      end
    end
  end

  task automatic after_edge();
    @(posedge clk);
    #5;
  endtask

  function automatic int lm(int c); return main_pin[c] ^ main_act_low[c]; endfunction
  function automatic int lc(int c); return comp_pin[c] ^ comp_act_low[c]; endfunction

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2718);
    // R1: enables requested while held in reset
    ch_enable = '1; pair_mode = '1;
    repeat (3) @(negedge clk);
    chk("R1", "main_oe in reset", main_oe, 0);
    chk("R1", "comp_oe in reset", comp_oe, 0);
    @(negedge clk); ch_enable = '0; rst_n = 1'b1; sb_on = 1'b1;
    after_edge();
    chk("R2", "main_oe disabled", main_oe, 0);
    chk("R2", "comp_oe disabled", comp_oe, 0);

    // R4, R5, R6 with dead time 5 on channel 0
    @(negedge clk); ch_enable = 3'b001; pair_mode = 3'b001; dead_time = 5; pwm_in = '0;
    repeat (10) @(negedge clk);
    chk("R5", "comp active after long low", lc(0), 1);
    pwm_in[0] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      after_edge();
      if (k == 1) chk("R6", "comp off at once", lc(0), 0);
      if (k == 5) chk("R4", "main still in gap", lm(0), 0);
      if (k == 6) chk("R4", "main on after gap", lm(0), 1);
    end
    // R10: active-low on both pins, both pins high in the gap
    @(negedge clk); main_act_low[0] = 1'b1; comp_act_low[0] = 1'b1;
    #1 chk("R10", "main pin active-low", main_pin[0], 0);
    @(negedge clk); pwm_in[0] = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      after_edge();
      if (k == 1) chk("R6", "main off at once", lm(0), 0);
      if (k == 3) begin
        chk("R10", "main pin idle in gap", main_pin[0], 1);
        chk("R10", "comp pin idle in gap", comp_pin[0], 1);
      end
      if (k == 5) chk("R5", "comp still in gap", lc(0), 0);
      if (k == 6) chk("R10", "comp pin active low", comp_pin[0], 0);
    end
    // R8: high pulse of 5 edges with dead time 5 never activates main
    @(negedge clk); main_act_low[0] = 1'b0; comp_act_low[0] = 1'b0; pwm_in[0] = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      after_edge();
      chk("R8", "no runt on main", lm(0), 0);
    end
    @(negedge clk); pwm_in[0] = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      after_edge();
      chk("R8", "comp idle after short pulse", lc(0), 0);
    end
    // R11: code 300 clamps to 40
    @(negedge clk); dead_time = 300; pwm_in[0] = 1'b1;
    for (int k = 1; k <= 41; k++) begin
      after_edge();
      if (k == 40) chk("R11", "main in clamped gap", lm(0), 0);
      if (k == 41) chk("R11", "main on after clamp", lm(0), 1);
    end
    // R9: zero dead time, exact inverse
    @(negedge clk); dead_time = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pwm_in[0] = k[0];
      after_edge();
      chk("R9", "inverse pair", lc(0), 1 - lm(0));
    end
    // R3: single mode, no delay, comp tristated
    @(negedge clk); pair_mode[0] = 1'b0; dead_time = 7; pwm_in[0] = 1'b0;
    @(negedge clk); pwm_in[0] = 1'b1;
    after_edge();
    chk("R3", "main follows pwm", lm(0), 1);
    chk("R3", "comp tristated", comp_oe[0], 0);
    // R12: force_safe keeps drivers, idles outputs
    @(negedge clk); force_safe = 1'b1;
    after_edge();
    chk("R12", "main idle when forced", lm(0), 0);
    chk("R12", "main_oe kept", main_oe[0], 1);
    @(negedge clk); force_safe = 1'b0;

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 9) < 2) pwm_in[c] = ~pwm_in[c];
      if ($urandom_range(0, 199) == 0) begin
        case ($urandom_range(0, 4))
          0: dead_time = 0;
          1: dead_time = 1;
          2: dead_time = MAXDT;
          3: dead_time = MAXDT + 1 + $urandom_range(0, 3000);
          default: dead_time = $urandom_range(0, 12);
        endcase
      end
      if ($urandom_range(0, 99) == 0) begin
        ch_enable = $urandom_range(0, 7) | 3'b001;
        pair_mode = $urandom_range(0, 7);
        main_act_low = $urandom_range(0, 7);
        comp_act_low = $urandom_range(0, 7);
      end
      force_safe = ($urandom_range(0, 149) == 0);
    end
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule